// File: doc/BRIEF.md
# Priority-Select Byte-Enable Merger

This combinational block builds one cache-line-wide access out of several buffered memory requests that fall on the same line. It receives a square address-match array and one record for each buffer slot. Each record holds a data word the width of the line and one enable bit per byte.

The block finds the lowest-numbered match row that has any bit set. It takes every record flagged in that row and merges them with a balanced OR tree, separately for data and for byte enables. The merged record drives a byte-enabled line port. The flagged set is also returned as a selection vector, so that the surrounding buffer can retire those entries once the line access is done.

The match array is produced elsewhere. The block holds no state, and its outputs follow its inputs within the same cycle.

Top module: `bemerge_top`

## Requirements
- R1: `valid_o` is 1 exactly when at least one bit of `match_i` is 1.
- R2: Bit `i*NUM_REQ+j` of `match_i` means request i and request j address the same line. Row i is `match_i[i*NUM_REQ +: NUM_REQ]`. `sel_o` equals the lowest-indexed row that is non-zero.
- R3: `data_o` is the bitwise OR of `data_i[j*DATA_W +: DATA_W]` over every j with `sel_o[j]` = 1.
- R4: `be_o` is the bitwise OR of `be_i[j*BE_W +: BE_W]` over every j with `sel_o[j]` = 1. Bit k of a record's enable field covers byte k of its data.
- R5: When every bit of `match_i` is 0, `data_o`, `be_o`, `sel_o` and `valid_o` are all 0, whatever the record contents are.
- R6: The data and enables of a record whose bit is 0 in the chosen row have no effect on any output.
- R7: Rows with a higher index than the chosen row have no effect on any output.
- R8: The outputs depend only on the present inputs. They reflect a change of input in the same cycle, with no register on the path.
- R9: A chosen row whose own diagonal bit is 0 is still honoured as given: only the records flagged in that row are merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| match_i | input | NUM_REQ*NUM_REQ | Address-match array; row i at [i*NUM_REQ +: NUM_REQ] |
| data_i | input | NUM_REQ*DATA_W | Per-record line data; record j at [j*DATA_W +: DATA_W] |
| be_i | input | NUM_REQ*BE_W | Per-record byte enables; record j at [j*BE_W +: BE_W] |
| data_o | output | DATA_W | Merged line data |
| be_o | output | BE_W | Merged byte enables |
| sel_o | output | NUM_REQ | Records merged into this access |
| valid_o | output | 1 | Some match row is non-empty |

## Verification
The hardest case to reach from the ports is a leak from outside the chosen row. This happens when a later row, or a record that is not flagged, disturbs the output. Random OR-merged data tends to hide such a leak, because the extra bits are often already set.

The stimulus therefore gives every record a distinct byte pattern and a single distinct enable bit, so that any record that slips in shows up as its own bits. Directed cases place junk in rows below the chosen one and in unflagged records. Grouped random traffic then builds symmetric match arrays from random line identifiers, as a real buffer would.

// File: rtl/bemerge_pkg.sv
package bemerge_pkg;
  localparam int unsigned DEF_NUM_REQ = 8;
  localparam int unsigned DEF_DATA_W  = 128;
  localparam int unsigned DEF_BE_W    = DEF_DATA_W / 8;
endpackage

// File: rtl/bemerge_row_any.sv
// OR-reduce every match row into one request bit per row
module bemerge_row_any #(
  parameter int unsigned NUM_REQ = bemerge_pkg::DEF_NUM_REQ
) (
  input  logic [NUM_REQ*NUM_REQ-1:0] match_i,
  output logic [NUM_REQ-1:0]         row_any_o
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_row
    assign row_any_o[i] = |match_i[i*NUM_REQ +: NUM_REQ];
  end
endmodule

// File: rtl/bemerge_prio.sv
// Lowest-index-wins priority picker with one-hot output
module bemerge_prio #(
  parameter int unsigned NUM_REQ = bemerge_pkg::DEF_NUM_REQ
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               any_o
);
  logic [NUM_REQ-1:0] lower_busy;

  assign lower_busy[0] = 1'b0;
  for (genvar i = 1; i < NUM_REQ; i++) begin : g_chain
    assign lower_busy[i] = lower_busy[i-1] | req_i[i-1];
  end

  assign grant_o = req_i & ~lower_busy;
  assign any_o   = |req_i;
endmodule

// File: rtl/bemerge_row_sel.sv
// One-hot AND-OR pick of the granted match row
module bemerge_row_sel #(
  parameter int unsigned NUM_REQ = bemerge_pkg::DEF_NUM_REQ
) (
  input  logic [NUM_REQ*NUM_REQ-1:0] match_i,
  input  logic [NUM_REQ-1:0]         grant_i,
  output logic [NUM_REQ-1:0]         sel_o
);
  for (genvar j = 0; j < NUM_REQ; j++) begin : g_col
    logic [NUM_REQ-1:0] col;
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
      assign col[i] = match_i[i*NUM_REQ + j];
    end
    assign sel_o[j] = |(col & grant_i);
  end
endmodule

// File: rtl/bemerge_or_tree.sv
// Balanced OR tree over NUM_IN words, heap-indexed
module bemerge_or_tree #(
  parameter int unsigned NUM_IN = bemerge_pkg::DEF_NUM_REQ,
  parameter int unsigned WIDTH  = bemerge_pkg::DEF_DATA_W
) (
  input  logic [NUM_IN*WIDTH-1:0] in_i,
  output logic [WIDTH-1:0]        out_o
);
  localparam int unsigned LVL    = (NUM_IN > 1) ? $clog2(NUM_IN) : 0;
  localparam int unsigned LEAVES = 1 << LVL;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [WIDTH-1:0] node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_IN) begin : g_used
      assign node[LEAVES-1+k] = in_i[k*WIDTH +: WIDTH];
    end else begin : g_pad
      assign node[LEAVES-1+k] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_inner
    assign node[n] = node[2*n+1] | node[2*n+2];
  end

  assign out_o = node[0];
endmodule

// File: rtl/bemerge_top.sv
module bemerge_top #(
  parameter int unsigned NUM_REQ = bemerge_pkg::DEF_NUM_REQ,
  parameter int unsigned DATA_W  = bemerge_pkg::DEF_DATA_W,
  parameter int unsigned BE_W    = bemerge_pkg::DEF_BE_W
) (
  input  logic [NUM_REQ*NUM_REQ-1:0] match_i,
  input  logic [NUM_REQ*DATA_W-1:0]  data_i,
  input  logic [NUM_REQ*BE_W-1:0]    be_i,
  output logic [DATA_W-1:0]          data_o,
  output logic [BE_W-1:0]            be_o,
  output logic [NUM_REQ-1:0]         sel_o,
  output logic                       valid_o
);
  localparam int unsigned REC_W = DATA_W + BE_W;

  logic [NUM_REQ-1:0]       row_any;
  logic [NUM_REQ-1:0]       grant;
  logic [NUM_REQ-1:0]       sel;
  logic [NUM_REQ*REC_W-1:0] gated;
  logic [REC_W-1:0]         merged;

  bemerge_row_any #(.NUM_REQ(NUM_REQ)) row_any_i (
    .match_i   (match_i),
    .row_any_o (row_any)
  );

  bemerge_prio #(.NUM_REQ(NUM_REQ)) prio_i (
    .req_i   (row_any),
    .grant_o (grant),
    .any_o   (valid_o)
  );

  bemerge_row_sel #(.NUM_REQ(NUM_REQ)) row_sel_i (
    .match_i (match_i),
    .grant_i (grant),
    .sel_o   (sel)
  );

  // zero out records not in the chosen row before merging
  for (genvar j = 0; j < NUM_REQ; j++) begin : g_gate
    assign gated[j*REC_W +: REC_W] =
      {data_i[j*DATA_W +: DATA_W], be_i[j*BE_W +: BE_W]} & {REC_W{sel[j]}};
  end

  bemerge_or_tree #(.NUM_IN(NUM_REQ), .WIDTH(REC_W)) or_tree_i (
    .in_i  (gated),
    .out_o (merged)
  );

  assign data_o = merged[REC_W-1 -: DATA_W];
  assign be_o   = merged[BE_W-1:0];
  assign sel_o  = sel;
endmodule

// File: rtl/bemerge_chk.sv
module bemerge_chk #(
  parameter int unsigned NUM_REQ = bemerge_pkg::DEF_NUM_REQ,
  parameter int unsigned DATA_W  = bemerge_pkg::DEF_DATA_W,
  parameter int unsigned BE_W    = bemerge_pkg::DEF_BE_W
) (
  input logic [NUM_REQ*NUM_REQ-1:0] match_i,
  input logic [NUM_REQ*DATA_W-1:0]  data_i,
  input logic [NUM_REQ*BE_W-1:0]    be_i,
  input logic [DATA_W-1:0]          data_o,
  input logic [BE_W-1:0]            be_o,
  input logic [NUM_REQ-1:0]         sel_o,
  input logic                       valid_o
);
  logic             row_ok;
  logic [NUM_REQ-1:0] miss;

  always_comb begin
    logic earlier_empty;
    earlier_empty = 1'b1;
    row_ok = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (earlier_empty && (match_i[i*NUM_REQ +: NUM_REQ] != '0)) begin
        row_ok = (sel_o == match_i[i*NUM_REQ +: NUM_REQ]);
        earlier_empty = 1'b0;
      end
    end
    for (int j = 0; j < NUM_REQ; j++) begin
      miss[j] = sel_o[j] &&
                (((data_i[j*DATA_W +: DATA_W] & ~data_o) != '0) ||
                 ((be_i[j*BE_W +: BE_W] & ~be_o) != '0));
    end
  end

  always_comb begin
    // R1
    valid_chk: assert (valid_o == (match_i != '0));
    // R2
    sel_row_chk: assert (!valid_o || row_ok);
    // R5
    idle_zero_chk: assert (valid_o || (data_o == '0 && be_o == '0 && sel_o == '0));
    // R3 R4
    merge_cover_chk: assert (miss == '0);
  end
endmodule

bind bemerge_top bemerge_chk #(
  .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .BE_W(BE_W)
) chk_i (.*);

// File: tb/bemerge_tb_top.sv
module bemerge_tb_top;
  localparam int N  = 8;
  localparam int DW = 128;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [N*N-1:0]  match;
  logic [N*DW-1:0] data;
  logic [N*BW-1:0] be;
  logic [DW-1:0]   data_o;
  logic [BW-1:0]   be_o;
  logic [N-1:0]    sel_o;
  logic            valid_o;

  bemerge_top #(.NUM_REQ(N), .DATA_W(DW), .BE_W(BW)) dut_i (
    .match_i (match), .data_i (data), .be_i (be),
    .data_o (data_o), .be_o (be_o), .sel_o (sel_o), .valid_o (valid_o)
  );

  typedef struct {
    string         tag;
    logic          v;
    logic [N-1:0]  sel;
    logic [DW-1:0] d;
    logic [BW-1:0] b;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;
  int checks = 0;
  int errors = 0;

  function automatic exp_t model(input logic [N*N-1:0] m, input logic [N*DW-1:0] dd,
                                 input logic [N*BW-1:0] bb, input string tag);
    exp_t e;
    e.tag = tag; e.v = 1'b0; e.sel = '0; e.d = '0; e.b = '0;
    for (int i = 0; i < N; i++)
      if (!e.v && m[i*N +: N] != '0) begin
        e.v = 1'b1;
        e.sel = m[i*N +: N];
      end
    for (int j = 0; j < N; j++)
      if (e.sel[j]) begin
        e.d |= dd[j*DW +: DW];
        e.b |= bb[j*BW +: BW];
      end
    return e;
  endfunction

  // driver: change inputs just after a rising edge, queue the expectation
  task automatic apply(input logic [N*N-1:0] m, input logic [N*DW-1:0] dd,
                       input logic [N*BW-1:0] bb, input string tag);
    @(posedge clk);
    match = m; data = dd; be = bb;
    sb_q.push_back(model(m, dd, bb, tag));
  endtask

  // monitor: half a cycle after the drive, same cycle (R8)
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      checks++;
      if (valid_o !== mon_e.v) begin
        errors++;
        $display("FAIL R1 %s valid act=%0b exp=%0b", mon_e.tag, valid_o, mon_e.v);
      end
      checks++;
      if (sel_o !== mon_e.sel) begin
        errors++;
        $display("FAIL R2 %s sel act=%h exp=%h", mon_e.tag, sel_o, mon_e.sel);
      end
      checks++;
      if (data_o !== mon_e.d) begin
        errors++;
        $display("FAIL R3 %s data act=%h exp=%h", mon_e.tag, data_o, mon_e.d);
      end
      checks++;
      if (be_o !== mon_e.b) begin
        errors++;
        $display("FAIL R4 %s be act=%h exp=%h", mon_e.tag, be_o, mon_e.b);
      end
    end
  end

  function automatic logic [N*N-1:0] set_row(input logic [N*N-1:0] m, input int r,
                                            input logic [N-1:0] v);
    logic [N*N-1:0] t;
    t = m;
    t[r*N +: N] = v;
    return t;
  endfunction

  logic [N*DW-1:0] pat_d;
  logic [N*BW-1:0] pat_b;
  logic [N*N-1:0]  m;

  initial begin
    // distinct per-record patterns expose any leaking record
    for (int k = 0; k < N; k++) begin
      pat_d[k*DW +: DW] = {(DW/8){8'(8'h11 * (k + 1))}} ^ (DW'(1) << (k * 9));
      pat_b[k*BW +: BW] = BW'(1) << (k % BW);
    end
    match = '0; data = pat_d; be = pat_b;
    repeat (3) @(posedge clk);
    // R5: reset-state idle, records full of data
    apply('0, pat_d, pat_b, "R5 idle");
    rst_ni = 1'b1;

    apply(set_row('0, 0, 8'h01), pat_d, pat_b, "R2 row0 self");
    m = set_row('0, 2, 8'ha4);
    m = set_row(m, 5, 8'ha4);
    m = set_row(m, 7, 8'ha4);
    apply(m, pat_d, pat_b, "R3 row2 group");
    // R7: junk in later row leaves result unchanged
    m = set_row(m, 6, 8'h43);
    apply(m, pat_d, pat_b, "R7 later rows ignored");
    // R6: scramble unflagged records
    begin
      logic [N*DW-1:0] d2;
      logic [N*BW-1:0] b2;
      d2 = pat_d; b2 = pat_b;
      d2[0 +: DW] = '1; d2[3*DW +: DW] = '1; b2[0 +: BW] = '1; b2[6*BW +: BW] = '1;
      apply(m, d2, b2, "R6 unflagged ignored");
    end
    // R4: full line from all eight, two bytes each
    begin
      logic [N*BW-1:0] b3;
      for (int k = 0; k < N; k++) b3[k*BW +: BW] = BW'(3) << (2 * k);
      apply(set_row('0, 0, 8'hff), pat_d, b3, "R4 full line");
    end
    apply(set_row('0, 7, 8'h80), pat_d, pat_b, "R2 last row only");
    // R9: chosen row without its diagonal bit
    apply(set_row(set_row('0, 3, 8'h01), 4, 8'h10), pat_d, pat_b, "R9 no diagonal");
    apply('1, pat_d, pat_b, "R2 all ones");
    apply('0, pat_d, pat_b, "R5 back to idle");

    // grouped random traffic: symmetric match from line ids
    for (int t = 0; t < 300; t++) begin
      logic [N-1:0] act;
      int lid [N];
      logic [N*DW-1:0] rd;
      logic [N*BW-1:0] rb;
      act = N'($urandom);
      for (int k = 0; k < N; k++) lid[k] = int'($urandom % 3);
      m = '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          m[i*N + j] = act[i] & act[j] & (lid[i] == lid[j]);
      for (int w = 0; w < N*DW/32; w++) rd[w*32 +: 32] = $urandom;
      for (int w = 0; w < N*BW/32; w++) rb[w*32 +: 32] = $urandom;
      apply(m, (t % 2 == 0) ? pat_d : rd, (t % 2 == 0) ? pat_b : rb, "R3 R4 R8 grouped");
    end
    // sparse unstructured arrays
    for (int t = 0; t < 60; t++) begin
      m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      apply(m, pat_d, pat_b, "R7 R9 sparse");
    end

    @(posedge clk);
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule